// File: doc/BRIEF.md
# Laser Diode Output Mode and Current Code Controller

This block chooses which of three laser diode outputs (BD, DVD or CD) is active and supplies the digital current code for the diode driver's current DAC. Software writes a configuration word, which holds a 2-bit output mode and an analog/digital control bit. It also writes an 11-bit current code whose top bit is a sign bit. The block drives one-hot output enables and the code that goes to the DAC.

The block protects the diode whenever the output mode changes. It clears the stored current code to zero and starts a settle window of `SETTLE_CYCLES` clocks. During that window every enable stays low, the DAC code is zero, and current-code writes are dropped. When analog control is selected, the digital code sent to the DAC is held at zero. The stored code is kept, so it returns when digital control is selected again.

Top module: `ldd_mode_ctrl`

## Requirements
- R1: After reset, all three enables are low, `dac_code` is 0 and `settling` is low; the mode is 00 and the stored code is 0.
- R2: Outside the settle window, mode 2'b11 raises only `out_bd`, mode 2'b10 raises only `out_dvd`, and mode 2'b01 raises only `out_cd`. At most one enable is high at any time.
- R3: In mode 2'b00 all enables are low and `dac_code` is 0, even after a valid code write.
- R4: A code write with bit 10 clear, made outside the settle window in digital control with an output enabled, appears on `dac_code` in the cycle after the write edge.
- R5: A code write with bit 10 set is ignored, so `dac_code` keeps its previous value.
- R6: A configuration write whose mode differs from the current mode clears the stored code to 0. After the settle window, `dac_code` is 0 until a new code is written.
- R7: A mode change raises `settling` for exactly `SETTLE_CYCLES` cycles, starting with the cycle after the write edge. During that time all enables are low and `dac_code` is 0. The new enable rises in the following cycle.
- R8: Code writes made while `settling` is high are ignored.
- R9: With the analog bit (`cfg_analog`=1) set, `dac_code` is 0 and the stored code is kept. A configuration write that repeats the current mode changes only the analog bit: it starts no settle window and clears no code.
- R10: A mode change made during a settle window restarts the full `SETTLE_CYCLES` window.
- R11: When a mode change and a valid code write arrive in the same cycle, the mode change wins and the stored code becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Output mode: 11 BD, 10 DVD, 01 CD, 00 off |
| cfg_analog | input | 1 | 1 selects analog current control, 0 selects the digital code |
| code_wr | input | 1 | Current code write strobe |
| code_wdata | input | CODE_W | Current code; the top bit is the sign bit |
| out_bd | output | 1 | BD output enable |
| out_dvd | output | 1 | DVD output enable |
| out_cd | output | 1 | CD output enable |
| dac_code | output | CODE_W | Code sent to the current DAC |
| settling | output | 1 | High during the mode-change settle window |

## Verification
The bench measures the settle window to the exact cycle. An off-by-one counter would raise the new enable one cycle early or late. It restarts the window with a second mode change partway through; a design that ignored that write would enable the old target too soon. It writes codes during the window, writes codes with the sign bit set, and issues a mode change and a code write in the same cycle. A design that got these wrong would drive a nonzero current right after a mode switch, or would accept a negative code. The bench also toggles the analog bit without changing the mode and confirms that the stored code comes back. A design that cleared the code or started a window on such a write would show zero or a raised `settling` there.

// File: rtl/ldd_mode_ctrl.sv
module ldd_mode_ctrl #(
  parameter int CODE_W        = 11,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_analog,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] code_wdata,
  output logic              out_bd,
  output logic              out_dvd,
  output logic              out_cd,
  output logic [CODE_W-1:0] dac_code,
  output logic              settling
);

  localparam int             CNT_W    = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);
  localparam logic [1:0]     M_OFF    = 2'b00;
  localparam logic [1:0]     M_CD     = 2'b01;
  localparam logic [1:0]     M_DVD    = 2'b10;
  localparam logic [1:0]     M_BD     = 2'b11;

  logic [1:0]        mode_q;
  logic              analog_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  wait_q;

  logic busy, mode_chg, code_take, live;

  assign busy      = (wait_q != '0);
  assign mode_chg  = cfg_wr && (cfg_mode != mode_q);
  assign code_take = code_wr && !busy && !mode_chg && !code_wdata[CODE_W-1];
  assign live      = !busy && (mode_q != M_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_OFF;
      analog_q <= 1'b0;
      code_q   <= '0;
      wait_q   <= '0;
    end else begin
      if (cfg_wr) begin
        mode_q   <= cfg_mode;
        analog_q <= cfg_analog;
      end
      if (mode_chg)  wait_q <= CNT_LOAD;
      else if (busy) wait_q <= wait_q - 1'b1;
      if (mode_chg)       code_q <= '0;
      else if (code_take) code_q <= code_wdata;
    end
  end

  assign out_bd   = live && (mode_q == M_BD);
  assign out_dvd  = live && (mode_q == M_DVD);
  assign out_cd   = live && (mode_q == M_CD);
  assign dac_code = (live && !analog_q) ? code_q : '0;
  assign settling = busy;

endmodule

// File: rtl/ldd_mode_ctrl_chk.sv
module ldd_mode_ctrl_chk #(
  parameter int CODE_W        = 11,
  parameter int SETTLE_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [1:0]        cfg_mode,
  input logic              cfg_analog,
  input logic              code_wr,
  input logic [CODE_W-1:0] code_wdata,
  input logic              out_bd,
  input logic              out_dvd,
  input logic              out_cd,
  input logic [CODE_W-1:0] dac_code,
  input logic              settling
);

  logic [1:0] mode_sh;
  logic       analog_sh;
  int         run_len;
  logic       chg_now;

  assign chg_now = cfg_wr && (cfg_mode != mode_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_sh   <= 2'b00;
      analog_sh <= 1'b0;
      run_len   <= 0;
    end else begin
      if (cfg_wr) begin
        mode_sh   <= cfg_mode;
        analog_sh <= cfg_analog;
      end
      if (chg_now)       run_len <= 1;
      else if (settling) run_len <= run_len + 1;
      else               run_len <= 0;
    end
  end

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({out_bd, out_dvd, out_cd})); // R2
  AST_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n) (mode_sh == 2'b00) |-> (!out_bd && !out_dvd && !out_cd && dac_code == '0)); // R3
  AST_SIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n) (code_wr && code_wdata[CODE_W-1] && !cfg_wr && !settling) |=> $stable(dac_code)); // R5
  AST_CHG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) chg_now |=> (settling && dac_code == '0)); // R6
  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) settling |-> (!out_bd && !out_dvd && !out_cd && dac_code == '0)); // R7
  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) settling |-> (run_len <= SETTLE_CYCLES)); // R7
  AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(settling) |-> ($past(run_len) == SETTLE_CYCLES)); // R10
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n) (code_wr && settling && !cfg_wr) |=> (dac_code == '0)); // R8
  AST_ANALOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n) analog_sh |-> (dac_code == '0)); // R9

endmodule

bind ldd_mode_ctrl ldd_mode_ctrl_chk #(.CODE_W(CODE_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (.*);

// File: tb/ldd_mode_ctrl_bench.sv
module ldd_mode_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int CW    = 11;
  localparam int N     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_analog = 1'b0, code_wr = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [CW-1:0] code_wdata = '0;
  logic out_bd, out_dvd, out_cd, settling;
  logic [CW-1:0] dac_code;

  ldd_mode_ctrl #(.CODE_W(CW), .SETTLE_CYCLES(N)) u_ldd_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_analog(cfg_analog), .code_wr(code_wr), .code_wdata(code_wdata),
    .out_bd(out_bd), .out_dvd(out_dvd), .out_cd(out_cd),
    .dac_code(dac_code), .settling(settling));

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    int            cyc;
    logic [2:0]    en;
    logic [CW-1:0] code;
    logic          busy;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (expq.size() > 0 && expq[0].cyc <= cyc) begin
      exp_t  e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      checks++;
      if (e.cyc != cyc || {out_bd, out_dvd, out_cd} != e.en || dac_code != e.code || settling != e.busy) begin
        errors++;
        $display("FAIL %s: en=%b code=%h settling=%b, expected en=%b code=%h settling=%b",
                 t, {out_bd, out_dvd, out_cd}, dac_code, settling, e.en, e.code, e.busy);
      end
    end
  end

  task automatic tick(input string tag, input logic [2:0] en, input logic [CW-1:0] code, input logic busy);
    exp_t e;
    e.cyc = cyc + 1; e.en = en; e.code = code; e.busy = busy;
    expq.push_back(e);
    tagq.push_back(tag);
    @(negedge clk); #1;
    cfg_wr = 1'b0;
    code_wr = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic a);
    cfg_wr = 1'b1; cfg_mode = m; cfg_analog = a;
  endtask

  task automatic set_code(input logic [CW-1:0] v);
    code_wr = 1'b1; code_wdata = v;
  endtask

  task automatic settle_rest(input string tag);
    for (int i = 1; i < N; i++) tick(tag, 3'b000, '0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    tick("R1 reset state", 3'b000, '0, 1'b0);

    set_cfg(2'b11, 1'b0);
    tick("R7 settle start BD", 3'b000, '0, 1'b1);
    tick("R7 settle window", 3'b000, '0, 1'b1);
    set_code(11'h155);
    tick("R8 write during settle", 3'b000, '0, 1'b1);
    for (int i = 3; i < N; i++) tick("R7 settle window", 3'b000, '0, 1'b1);
    tick("R2 BD enabled, R8 code still zero", 3'b100, '0, 1'b0);

    set_code(11'h123);
    tick("R4 code accepted", 3'b100, 11'h123, 1'b0);
    set_code(11'h5FF);
    tick("R5 sign bit write ignored", 3'b100, 11'h123, 1'b0);
    set_cfg(2'b11, 1'b1);
    tick("R9 analog forces zero, no settle", 3'b100, '0, 1'b0);
    set_code(11'h0F0);
    tick("R9 analog with code write", 3'b100, '0, 1'b0);
    set_cfg(2'b11, 1'b0);
    tick("R9 digital restores stored code", 3'b100, 11'h0F0, 1'b0);

    set_cfg(2'b10, 1'b0);
    tick("R6 mode change to DVD", 3'b000, '0, 1'b1);
    tick("R7 settle window", 3'b000, '0, 1'b1);
    tick("R7 settle window", 3'b000, '0, 1'b1);
    set_cfg(2'b01, 1'b0);
    tick("R10 restart toward CD", 3'b000, '0, 1'b1);
    settle_rest("R10 restarted window");
    tick("R2 CD enabled, R6 code cleared", 3'b001, '0, 1'b0);

    set_code(11'h3FF);
    tick("R4 largest positive code", 3'b001, 11'h3FF, 1'b0);
    set_cfg(2'b10, 1'b0);
    settle_rest("R7 settle before DVD");
    tick("R7 settle last cycle", 3'b000, '0, 1'b1);
    tick("R2 DVD enabled, R6 code cleared", 3'b010, '0, 1'b0);

    set_code(11'h2AA);
    tick("R4 code in DVD", 3'b010, 11'h2AA, 1'b0);
    set_cfg(2'b11, 1'b0);
    set_code(11'h011);
    tick("R11 mode change beats code write", 3'b000, '0, 1'b1);
    settle_rest("R11 settle");
    tick("R11 BD enabled with zero code", 3'b100, '0, 1'b0);

    set_cfg(2'b00, 1'b0);
    tick("R3 mode off settle", 3'b000, '0, 1'b1);
    settle_rest("R3 settle");
    tick("R3 all outputs off", 3'b000, '0, 1'b0);
    set_code(11'h0AA);
    tick("R3 code write in off mode", 3'b000, '0, 1'b0);
    tick("R3 off mode stays quiet", 3'b000, '0, 1'b0);

    @(negedge clk); #1;
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R1 scoreboard: %0d items left, expected 0", expq.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: run hung, got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule